// File: doc/BRIEF.md
# DDR SDRAM command sequencer

This block is the command front end of a memory controller for a four-bank DDR SDRAM with 32-bit words. Once powered up, it takes one word-addressed read or write request at a time over a valid/ready handshake. Each request is split into bank, row and column. The block then drives an activate, followed by a read or write with auto-precharge. Every command appears on active-low chip-select, row-strobe, column-strobe and write-enable lines, and changes only on a rising clock edge.

After reset the block waits a power-up delay. It then closes every bank, runs two refreshes and loads the mode register with the CAS latency, burst length and burst order fixed at build time. From the CAS latency it also flags the cycle in which read data is due, with an extra flag for the half-cycle latency. An interval counter schedules a refresh at a steady rate. At an idle slot, an owed refresh wins over any waiting request.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While rst_n is low, the bus shows NOP, req_ready is 0 and rd_due is 0. The command codes on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode set 0000.
- R2: The first command after reset release is a precharge with A8=1, T_INIT cycles after the release. A refresh follows T_RP cycles later, a second refresh T_RFC cycles after that, and a mode set with BA=0 T_RFC cycles later. req_ready first rises T_MRD cycles after the mode set.
- R3: The mode word places the burst length code on A2:A0 (2→001, 4→010, 8→011) and the burst order on A3 (1 = interleaved). It places the CAS code on A6:A4 (2→010, 2.5→110, 3→011). All other bits are zero.
- R4: An activate carries req_addr[22:21] on BA and req_addr[20:9] on A11:A0.
- R5: The column command follows its activate by exactly T_RCD cycles on the same BA. It is a write (0100) for req_write=1 and a read (0101) otherwise. It carries req_addr[7:0] on A7:A0, req_addr[8] on A9, A8=1 and A11:A10=0.
- R6: No activate or refresh comes sooner than T_CLOSE = max(T_RAS−T_RCD,1) + BL/2 + T_RP cycles after a column command.
- R7: req_ready is 0 in the cycle after a request is accepted. While the block is ready and no request is valid, the bus stays at NOP.
- R8: rd_due pulses for one cycle exactly floor(CL) cycles after each read command, and never after a write. rd_due_half is high with it only when CL is 2.5.
- R9: After init a refresh falls due every T_REFI cycles. An idle block issues it the cycle after it falls due, ahead of any valid request, so idle refreshes are exactly T_REFI apart. Under constant requests, no gap between refreshes exceeds T_REFI + T_RCD + T_CLOSE + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address: bank, row, column |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_a | output | 12 | Row, column or mode word |
| rd_due | output | 1 | Read data starts in this cycle |
| rd_due_half | output | 1 | Data starts half a cycle after rd_due |

## Verification
Each command leaves the block one edge after the decision that makes it, so the bench timestamps every non-NOP command at the falling edge after it appears. It checks distances between timestamps instead of absolute cycles: T_INIT from reset release, T_RP, T_RFC and T_MRD during init, T_RCD from activate to column, and at least T_CLOSE to the next row-level command. rd_due is checked as exactly floor(CL) cycles after the read's timestamp. Idle refreshes are checked as exactly T_REFI apart, because the refresh goes out one edge after it falls due.

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq #(
  parameter int T_INIT    = 20000,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 7,
  parameter int T_RFC     = 10,
  parameter int T_MRD     = 2,
  parameter int T_REFI    = 1560,
  parameter int MAX_PEND  = 4,
  parameter int CAS_X2    = 5,
  parameter int BURST_LEN = 4,
  parameter int BURST_ILV = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [22:0] req_addr,
  output logic        cmd_cs_n,
  output logic        cmd_ras_n,
  output logic        cmd_cas_n,
  output logic        cmd_we_n,
  output logic [1:0]  cmd_ba,
  output logic [11:0] cmd_a,
  output logic        rd_due,
  output logic        rd_due_half
);
  localparam int CL_INT  = CAS_X2 / 2;
  localparam int CL_HALF = CAS_X2 % 2;
  localparam logic [2:0] CL_CODE = (CAS_X2 == 4) ? 3'b010 : (CAS_X2 == 5) ? 3'b110 : 3'b011;
  localparam logic [2:0] BL_CODE = (BURST_LEN == 2) ? 3'b001 : (BURST_LEN == 4) ? 3'b010 : 3'b011;
  localparam logic [11:0] MODE_WORD = {5'b0, CL_CODE, BURST_ILV != 0, BL_CODE};
  localparam int T_CLOSE = ((T_RAS > T_RCD) ? T_RAS - T_RCD : 1) + BURST_LEN / 2 + T_RP;
  localparam int TMAX = T_INIT + T_CLOSE + T_RFC + T_RP + T_RCD + T_MRD;
  localparam int TW = $clog2(TMAX + 1);
  localparam int RW = $clog2(T_REFI + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_PREA, S_REF1, S_REF2, S_IDLE, S_ACT, S_WAIT} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [3:0]    cmd;
  logic [8:0]    col;
  logic          wr_q;
  logic [RW-1:0] ref_cnt;
  logic [PW-1:0] pend;
  logic          armed;
  logic [3:0]    rd_pipe;

  wire ref_tick = armed && (ref_cnt == '0);
  wire ref_take = (st == S_IDLE) && (pend != '0);
  wire rd_issue = (st == S_ACT) && (tmr == '0) && !wr_q;

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd;
  assign req_ready   = (st == S_IDLE) && (pend == '0);
  assign rd_due      = rd_pipe[CL_INT];
  assign rd_due_half = rd_due && (CL_HALF != 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt <= RW'(T_REFI - 1);
      pend    <= '0;
      armed   <= 1'b0;
      rd_pipe <= '0;
    end else begin
      rd_pipe <= {rd_pipe[2:0], rd_issue};
      if (st == S_IDLE) armed <= 1'b1;
      if (armed) ref_cnt <= ref_tick ? RW'(T_REFI - 1) : ref_cnt - 1'b1;
      if (ref_tick && !ref_take && pend != PW'(MAX_PEND)) pend <= pend + 1'b1;
      else if (!ref_tick && ref_take) pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_PWR;
      tmr    <= TW'(T_INIT - 1);
      cmd    <= C_NOP;
      cmd_ba <= '0;
      cmd_a  <= '0;
      col    <= '0;
      wr_q   <= 1'b0;
    end else begin
      cmd <= C_NOP;
      if (st != S_IDLE && tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        case (st)
          S_PWR: begin
            cmd <= C_PRE; cmd_ba <= '0; cmd_a <= 12'h100;
            tmr <= TW'(T_RP - 1); st <= S_PREA;
          end
          S_PREA: begin
            cmd <= C_REF; tmr <= TW'(T_RFC - 1); st <= S_REF1;
          end
          S_REF1: begin
            cmd <= C_REF; tmr <= TW'(T_RFC - 1); st <= S_REF2;
          end
          S_REF2: begin
            cmd <= C_MRS; cmd_ba <= '0; cmd_a <= MODE_WORD;
            tmr <= TW'(T_MRD - 1); st <= S_WAIT;
          end
          S_IDLE: begin
            if (pend != '0) begin
              cmd <= C_REF; tmr <= TW'(T_RFC - 1); st <= S_WAIT;
            end else if (req_valid) begin
              cmd    <= C_ACT;
              cmd_ba <= req_addr[22:21];
              cmd_a  <= req_addr[20:9];
              col    <= req_addr[8:0];
              wr_q   <= req_write;
              tmr    <= TW'(T_RCD - 1);
              st     <= S_ACT;
            end
          end
          S_ACT: begin
            cmd   <= wr_q ? C_WR : C_RD;
            cmd_a <= {2'b00, col[8], 1'b1, col[7:0]};
            tmr   <= TW'(T_CLOSE - 1);
            st    <= S_WAIT;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk #(
  parameter int T_RCD   = 3,
  parameter int T_CLOSE = 8,
  parameter int CL_INT  = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cmd,
  input logic [11:0] a,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rd_due
);
  logic [15:0] since_act, since_col;
  wire is_act = cmd == 4'b0011;
  wire is_rd  = cmd == 4'b0101;
  wire is_col = is_rd || cmd == 4'b0100;
  wire is_ref = cmd == 4'b0001;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '1;
      since_col <= '1;
    end else begin
      since_act <= is_act ? 16'd1 : (since_act == '1 ? since_act : since_act + 16'd1);
      since_col <= is_col ? 16'd1 : (since_col == '1 ? since_col : since_col + 16'd1);
    end
  end

  a_r5_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act == 16'(T_RCD));
  a_r5_auto_pre: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> a[8]);
  a_r6_close_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_ref) |-> since_col >= 16'(T_CLOSE));
  a_r7_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> cmd == 4'b0111);
  a_r8_rd_due: assert property (@(posedge clk) disable iff (!rst_n)
    rd_due |-> $past(is_rd, CL_INT));
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk #(.T_RCD(T_RCD), .T_CLOSE(T_CLOSE), .CL_INT(CL_INT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}),
  .a(cmd_a), .req_valid(req_valid), .req_ready(req_ready), .rd_due(rd_due)
);

// File: tb/ddr_cmd_seq_bench.sv
module ddr_cmd_seq_bench;
  localparam int T_INIT = 20, T_RP = 2, T_RCD = 3, T_RAS = 6, T_RFC = 5, T_MRD = 2;
  localparam int T_REFI = 120, BL = 8;
  localparam int T_CLOSE = (T_RAS - T_RCD) + BL / 2 + T_RP;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 0, rst_n = 0, req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, rd_due, rd_due_half;
  logic [1:0] ba;
  logic [11:0] a;

  ddr_cmd_seq #(.T_INIT(T_INIT), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_REFI(T_REFI), .MAX_PEND(2), .CAS_X2(5), .BURST_LEN(BL), .BURST_ILV(1))
  u_ddr_cmd_seq (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(ba), .cmd_a(a), .rd_due(rd_due),
    .rd_due_half(rd_due_half));

  always #4 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0, lg_n = 0, rd_cnt = 0, rd_last = -1, first_rdy = -1;
  logic rd_half_last = 0;
  logic [3:0] lg_cmd [1024];
  logic [1:0] lg_ba [1024];
  logic [11:0] lg_a [1024];
  int lg_cyc [1024];
  wire [3:0] bus = {cs_n, ras_n, cas_n, we_n};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (bus != NOP && lg_n < 1024) begin
      lg_cmd[lg_n] = bus; lg_ba[lg_n] = ba; lg_a[lg_n] = a; lg_cyc[lg_n] = cyc; lg_n++;
    end
    if (rd_due) begin rd_cnt++; rd_last = cyc; rd_half_last = rd_due_half; end
    if (req_ready && first_rdy < 0) first_rdy = cyc;
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int find(input logic [3:0] c, input int from);
    for (int i = from; i < lg_n; i++) if (lg_cmd[i] == c) return i;
    return -1;
  endfunction

  task automatic send(input bit w, input logic [22:0] ad);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = ad;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R7 ready after accept", int'(req_ready), 0);
  endtask

  int rel_cyc;

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check(bus == NOP, "R1 bus in reset", int'(bus), int'(NOP));
    check(req_ready == 0 && rd_due == 0, "R1 ready/rd_due in reset", int'({req_ready, rd_due}), 0);
    rst_n = 1; rel_cyc = cyc;
  endtask

  task automatic t_init;
    int p, r1, r2, m;
    while (first_rdy < 0) @(negedge clk);
    p = find(PRE, 0); r1 = find(REF, 0); r2 = find(REF, r1 + 1); m = find(MRS, 0);
    check(p == 0 && r1 == 1 && r2 == 2 && m == 3, "R2 init order", lg_n, 4);
    if (p != 0 || r1 != 1 || r2 != 2 || m != 3) return;
    check(lg_cyc[p] - rel_cyc == T_INIT, "R2 power-up delay", lg_cyc[p] - rel_cyc, T_INIT);
    check(lg_a[p][8] == 1, "R2 precharge all", int'(lg_a[p][8]), 1);
    check(lg_cyc[r1] - lg_cyc[p] == T_RP, "R2 PRE to REF", lg_cyc[r1] - lg_cyc[p], T_RP);
    check(lg_cyc[r2] - lg_cyc[r1] == T_RFC, "R2 REF to REF", lg_cyc[r2] - lg_cyc[r1], T_RFC);
    check(lg_cyc[m] - lg_cyc[r2] == T_RFC, "R2 REF to MRS", lg_cyc[m] - lg_cyc[r2], T_RFC);
    check(first_rdy - lg_cyc[m] == T_MRD, "R2 ready after MRS", first_rdy - lg_cyc[m], T_MRD);
    check(lg_ba[m] == 0, "R2 MRS bank", int'(lg_ba[m]), 0);
    check(lg_a[m] == 12'h06B, "R3 mode word", int'(lg_a[m]), 'h06B);
  endtask

  task automatic t_col(input bit w, input logic [1:0] b, input logic [11:0] row,
                       input logic [8:0] cl, input string tag);
    int mk, ia, ic, rc0;
    logic [11:0] ecol;
    mk = lg_n; rc0 = rd_cnt;
    send(w, {b, row, cl});
    repeat (T_RCD + 6) @(negedge clk);
    ia = find(ACT, mk); ic = find(w ? WR : RD, mk);
    check(ia >= 0 && ic > ia, {tag, " R5 ACT then column"}, ic, ia + 1);
    if (ia < 0 || ic <= ia) return;
    check(lg_ba[ia] == b && lg_a[ia] == row, {tag, " R4 ACT bank/row"},
          int'({lg_ba[ia], lg_a[ia]}), int'({b, row}));
    ecol = {2'b00, cl[8], 1'b1, cl[7:0]};
    check(lg_a[ic] == ecol && lg_ba[ic] == b, {tag, " R5 column word"}, int'(lg_a[ic]), int'(ecol));
    check(lg_cyc[ic] - lg_cyc[ia] == T_RCD, {tag, " R5 tRCD"}, lg_cyc[ic] - lg_cyc[ia], T_RCD);
    if (w) check(rd_cnt == rc0, {tag, " R8 no rd_due on write"}, rd_cnt - rc0, 0);
    else begin
      check(rd_cnt == rc0 + 1, {tag, " R8 one rd_due"}, rd_cnt - rc0, 1);
      check(rd_last - lg_cyc[ic] == 2, {tag, " R8 CL delay"}, rd_last - lg_cyc[ic], 2);
      check(rd_half_last == 1, {tag, " R8 half flag"}, int'(rd_half_last), 1);
    end
    repeat (T_CLOSE + 2) @(negedge clk);
  endtask

  task automatic t_idle_refresh;
    int mk, other, last, prev;
    mk = lg_n;
    repeat (3 * T_REFI + 5) @(negedge clk);
    other = 0; last = -1; prev = -1;
    for (int i = mk; i < lg_n; i++) begin
      if (lg_cmd[i] != REF) other++;
      else begin prev = last; last = i; end
    end
    check(other == 0, "R7 NOP while idle", other, 0);
    check(prev >= 0, "R9 idle refreshes seen", prev, 0);
    if (prev >= 0)
      check(lg_cyc[last] - lg_cyc[prev] == T_REFI, "R9 idle period",
            lg_cyc[last] - lg_cyc[prev], T_REFI);
  endtask

  task automatic t_stream;
    int mk, refs, lastref, badgap, maxgap, badclose;
    mk = lg_n;
    @(negedge clk);
    req_valid = 1;
    for (int k = 0; k < 500; k++) begin
      req_write = k[0];
      req_addr = {k[1:0], 12'(k * 7), 9'(k * 13)};
      @(negedge clk);
    end
    req_valid = 0;
    repeat (T_CLOSE + 4) @(negedge clk);
    refs = 0; lastref = -1; badgap = 0; maxgap = 0; badclose = 0;
    for (int i = mk; i < lg_n; i++) begin
      if (lg_cmd[i] == REF) begin
        refs++;
        if (lastref >= 0 && lg_cyc[i] - lastref > maxgap) maxgap = lg_cyc[i] - lastref;
        lastref = lg_cyc[i];
      end
      if ((lg_cmd[i] == RD || lg_cmd[i] == WR) && i + 1 < lg_n &&
          lg_cyc[i + 1] - lg_cyc[i] < T_CLOSE) badclose++;
    end
    badgap = (maxgap > T_REFI + T_RCD + T_CLOSE + 2) ? 1 : 0;
    check(refs >= 3, "R9 refresh under load", refs, 3);
    check(badgap == 0, "R9 refresh gap under load", maxgap, T_REFI + T_RCD + T_CLOSE + 2);
    check(badclose == 0, "R6 close gap", badclose, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_init();
    t_col(1'b1, 2'd2, 12'hABC, 9'h1A5, "write");
    t_col(1'b0, 2'd1, 12'h123, 9'h0FF, "read");
    t_col(1'b0, 2'd3, 12'hFFF, 9'h100, "read-a9");
    t_idle_refresh();
    t_stream();
    finish_run();
  end
endmodule